// File: doc/BRIEF.md
# RTC Time Access Sequencer

This block runs complete time transactions against a nibble-wide serial clock chip. A host asks for one of three jobs with a start pulse and an opcode: fetch the whole time, load a new time, or run a power-up validity check. The block drives the chip-enable line and issues single-register read and write requests to a serial register master below it. It confirms that the chip is idle before it touches any time register. It also moves between the packed BCD bytes on the host side and the separate 4-bit registers in the chip.

The chip keeps the units digit of each field at an even address and the tens digit at the next odd address. Before a time transfer the block selects 24-hour mode, reads the control register back and examines the busy flag. While the chip is busy, the block releases chip enable, waits, and tries again, up to a retry limit. Once the transfer is finished, it holds chip enable low for a guard time and then pulses `done`.

The power-up check looks for the oscillator-stop flag. If that flag is set, the block switches the periodic interrupt off, starts an adjust cycle, waits for the chip to go idle, loads a default time and raises a flag that marks the time as invalid.

Top module: `rtc_time_seq`

## Requirements
- R1: While reset is held and after it is released, `ceOut`, `regReq`, `done`, `invalidTime` and `timeoutErr` are all 0.
- R2: A start pulse is accepted only in the idle state. The opcode values are 2'b01 (read time), 2'b10 (set time) and 2'b11 (check). Opcode 2'b00 produces no activity, and a start that arrives while a job is running is ignored. An accepted start clears `invalidTime` and `timeoutErr`.
- R3: Each read or set job raises `ceOut`, then writes 0x4 to control address 0xE, then reads address 0xE. This happens before any time register is accessed.
- R4: If bit 0 (busy) of that readback is 1, `ceOut` goes low for at least CE_GAP cycles. The job then raises `ceOut` again and repeats the R3 preamble.
- R5: When RETRY_LIMIT busy readbacks have occurred in one wait loop, the job stops without touching any time register. It sets `timeoutErr`, drops `ceOut` and ends with `done`.
- R6: A read job reads addresses 0,1,2,3,4,5,8,9,A,B,C,D,6 in that order. Each nibble read from an even address goes into bits 3:0 of the seconds, minutes, hours, day, month or year output, and the next odd address goes into bits 7:4. Address 6 fills `wdayOut`.
- R7: A set job writes the same address sequence as R6. Each write carries bits 3:0 of the field at the even address, bits 7:4 at the odd address, and `wdayIn` at address 6. Afterwards the time outputs show the values that were written.
- R8: After the last access, `ceOut` stays low for at least CE_GAP cycles before `done`. `done` is a one-cycle pulse, and `ceOut` is low while `done` is high.
- R9: A check job reads address 0xE with `ceOut` high. If bit 1 (oscillator stop) is 0, the job ends with no write and with `invalidTime` at 0.
- R10: If bit 1 is 1, the check writes 0x0 to address 7 and then 0x7 to address 0xE. It re-reads 0xE until bit 0 is 0, subject to the R5 limit. It then runs a set job with 00:00:00, day 0x01, month 0x01, year 0x00 and weekday 0, and it ends with `invalidTime` at 1.
- R11: `regReq` is a one-cycle pulse issued only while `ceOut` is high. No new request is issued before `regAck` answers the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Job request pulse |
| opcode | input | 2 | Job select (see R2) |
| secIn | input | 8 | Seconds to set, packed BCD |
| minIn | input | 8 | Minutes to set, packed BCD |
| hourIn | input | 8 | Hours to set, packed BCD |
| dayIn | input | 8 | Day of month to set, packed BCD |
| monIn | input | 8 | Month to set, packed BCD |
| yearIn | input | 8 | Year to set, packed BCD |
| wdayIn | input | 4 | Weekday to set |
| secOut | output | 8 | Seconds last read or written |
| minOut | output | 8 | Minutes last read or written |
| hourOut | output | 8 | Hours last read or written |
| dayOut | output | 8 | Day last read or written |
| monOut | output | 8 | Month last read or written |
| yearOut | output | 8 | Year last read or written |
| wdayOut | output | 4 | Weekday last read or written |
| done | output | 1 | Job finished pulse |
| invalidTime | output | 1 | Check found the oscillator stopped and loaded the default time |
| timeoutErr | output | 1 | Busy retry limit was reached |
| ceOut | output | 1 | Chip enable |
| regReq | output | 1 | Register access request pulse to the serial master |
| regWrite | output | 1 | 1 = write, 0 = read, valid with `regReq` |
| regAddr | output | 4 | Register address, valid with `regReq` |
| regWrData | output | 4 | Write nibble, valid with `regReq` |
| regAck | input | 1 | Access complete from the serial master |
| regRdData | input | 4 | Read nibble, valid with `regAck` |

## Verification
A wrong step index in the datapath shows up on the request port within one access. It appears as an address that breaks the 0,1,2,3,4,5,8,9,A,B,C,D,6 order, or as a nibble placed in the wrong half of an output byte once `done` pulses. A control state that skips the busy preamble or mishandles the retry count changes the logged access list and the `timeoutErr` flag, and this is visible at the job's own `done`. A gap counter that ends early appears as a chip-enable low interval shorter than CE_GAP, which a chip model measures at every rising edge of chip enable.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;
  localparam int NIB_W      = 4;
  localparam int BYTE_W     = 2 * NIB_W;
  localparam int ADDR_W     = 4;
  localparam int NUM_FIELDS = 7;                      // six two-digit fields + weekday
  localparam int NUM_STEPS  = 2 * (NUM_FIELDS - 1) + 1;
  localparam int FIELD_W    = $clog2(NUM_FIELDS);
  localparam int STEP_W     = $clog2(NUM_STEPS);

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'hE;
  localparam logic [ADDR_W-1:0] ADDR_IRQ  = 4'h7;
  localparam logic [NIB_W-1:0]  CTRL_24H  = 4'h4;
  localparam logic [NIB_W-1:0]  CTRL_ADJ  = 4'h7;
  localparam logic [NIB_W-1:0]  IRQ_OFF   = 4'h0;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_READ  = 2'b01,
    OP_SET   = 2'b10,
    OP_CHECK = 2'b11
  } opcode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadHost;
    logic loadDefault;
    logic capNib;
    logic stepInc;
    logic stepClr;
  } dp_strobe_t;

  // even (units) address of each field; weekday last
  function automatic logic [ADDR_W-1:0] fieldBase(input logic [FIELD_W-1:0] f);
    case (f)
      3'd0:    fieldBase = 4'h0;
      3'd1:    fieldBase = 4'h2;
      3'd2:    fieldBase = 4'h4;
      3'd3:    fieldBase = 4'h8;
      3'd4:    fieldBase = 4'hA;
      3'd5:    fieldBase = 4'hC;
      default: fieldBase = 4'h6;
    endcase
  endfunction

  // default time loaded after an oscillator stop
  function automatic logic [BYTE_W-1:0] defaultByte(input int f);
    defaultByte = (f == 3 || f == 4) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/rtc_seq_data.sv
module rtc_seq_data
  import rtc_seq_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  dp_strobe_t                     strobe,
  input  logic [NUM_FIELDS-2:0][BYTE_W-1:0] hostBytes,
  input  logic [NIB_W-1:0]               hostWday,
  input  logic [NIB_W-1:0]               rdNib,
  output logic [NUM_FIELDS-2:0][BYTE_W-1:0] timeBytes,
  output logic [NIB_W-1:0]               timeWday,
  output logic [ADDR_W-1:0]              stepAddr,
  output logic [NIB_W-1:0]               stepWrNib,
  output logic                           lastStep
);
  localparam int WDAY_IDX = NUM_FIELDS - 1;

  logic [STEP_W-1:0]  stepIdx;
  logic [FIELD_W-1:0] curField;
  logic               curHi;
  logic               isWday;
  logic [BYTE_W-1:0]  fieldQ [NUM_FIELDS-1];
  logic [NIB_W-1:0]   wdayQ;

  assign isWday   = (stepIdx == STEP_W'(NUM_STEPS - 1));
  assign curField = isWday ? FIELD_W'(WDAY_IDX) : FIELD_W'(stepIdx >> 1);
  assign curHi    = !isWday && stepIdx[0];
  assign stepAddr = fieldBase(curField) | ADDR_W'(curHi);
  assign lastStep = isWday;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                stepIdx <= '0;
    else if (strobe.stepClr)  stepIdx <= '0;
    else if (strobe.stepInc && !isWday) stepIdx <= stepIdx + 1'b1;
  end

  for (genvar f = 0; f < NUM_FIELDS - 1; f++) begin : g_field
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   fieldQ[f] <= '0;
      else if (strobe.loadDefault) fieldQ[f] <= defaultByte(f);
      else if (strobe.loadHost)    fieldQ[f] <= hostBytes[f];
      else if (strobe.capNib && curField == FIELD_W'(f)) begin
        if (curHi) fieldQ[f][BYTE_W-1:NIB_W] <= rdNib;
        else       fieldQ[f][NIB_W-1:0]      <= rdNib;
      end
    end
    assign timeBytes[f] = fieldQ[f];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   wdayQ <= '0;
    else if (strobe.loadDefault) wdayQ <= '0;
    else if (strobe.loadHost)    wdayQ <= hostWday;
    else if (strobe.capNib && isWday) wdayQ <= rdNib;
  end
  assign timeWday = wdayQ;

  always_comb begin
    if (isWday)     stepWrNib = wdayQ;
    else if (curHi) stepWrNib = fieldQ[curField][BYTE_W-1:NIB_W];
    else            stepWrNib = fieldQ[curField][NIB_W-1:0];
  end

  // R6: the step index never runs past the weekday access
  assert_step_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    stepIdx < STEP_W'(NUM_STEPS));
  // R7: host load and nibble capture never collide
  assert_load_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadHost && strobe.capNib));
endmodule

// File: rtl/rtc_seq_ctrl.sv
module rtc_seq_ctrl
  import rtc_seq_pkg::*;
#(
  parameter int CE_GAP      = 175,
  parameter int RETRY_LIMIT = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        opcode,
  input  logic              regAck,
  input  logic              busyBit,
  input  logic              stopBit,
  input  logic [ADDR_W-1:0] stepAddr,
  input  logic [NIB_W-1:0]  stepWrNib,
  input  logic              lastStep,
  output logic              ceOut,
  output logic              regReq,
  output logic              regWrite,
  output logic [ADDR_W-1:0] regAddr,
  output logic [NIB_W-1:0]  regWrData,
  output logic              done,
  output logic              invalidTime,
  output logic              timeoutErr,
  output dp_strobe_t        strobe
);
  localparam int GAP_W   = $clog2(CE_GAP + 1);
  localparam int RETRY_W = $clog2(RETRY_LIMIT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CTL_WR, S_CTL_RD, S_RETRY_GAP, S_XFER, S_END_GAP,
    S_CHK_RD, S_CHK_INT, S_CHK_CTL, S_CHK_POLL
  } state_e;

  state_e             state;
  logic               pending;
  logic               opSet;
  logic [GAP_W-1:0]   gapCnt;
  logic [RETRY_W-1:0] retryCnt;
  logic               accessState;
  logic               ackSeen;
  logic               startOk;
  logic               gapDone;
  logic               retryLast;

  assign accessState = (state == S_CTL_WR) || (state == S_CTL_RD) || (state == S_XFER) ||
                       (state == S_CHK_RD) || (state == S_CHK_INT) ||
                       (state == S_CHK_CTL) || (state == S_CHK_POLL);
  assign regReq    = accessState && !pending;
  assign ackSeen   = regAck && pending;
  assign startOk   = (state == S_IDLE) && start && (opcode != OP_NONE);
  assign gapDone   = (gapCnt == GAP_W'(CE_GAP - 1));
  assign retryLast = (retryCnt == RETRY_W'(RETRY_LIMIT - 1));

  always_comb begin
    regWrite  = 1'b0;
    regAddr   = ADDR_CTRL;
    regWrData = '0;
    case (state)
      S_CTL_WR:  begin regWrite = 1'b1; regWrData = CTRL_24H; end
      S_XFER:    begin regWrite = opSet; regAddr = stepAddr; regWrData = stepWrNib; end
      S_CHK_INT: begin regWrite = 1'b1; regAddr = ADDR_IRQ; regWrData = IRQ_OFF; end
      S_CHK_CTL: begin regWrite = 1'b1; regWrData = CTRL_ADJ; end
      default:   ;
    endcase
  end

  always_comb begin
    strobe             = '0;
    strobe.loadHost    = startOk && (opcode == OP_SET);
    strobe.loadDefault = (state == S_CHK_POLL) && ackSeen && !busyBit;
    strobe.stepClr     = (state == S_IDLE);
    strobe.stepInc     = (state == S_XFER) && ackSeen;
    strobe.capNib      = (state == S_XFER) && ackSeen && !opSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      pending     <= 1'b0;
      opSet       <= 1'b0;
      gapCnt      <= '0;
      retryCnt    <= '0;
      ceOut       <= 1'b0;
      done        <= 1'b0;
      invalidTime <= 1'b0;
      timeoutErr  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (regReq)  pending <= 1'b1;
      if (ackSeen) pending <= 1'b0;
      case (state)
        S_IDLE: if (startOk) begin
          timeoutErr  <= 1'b0;
          invalidTime <= 1'b0;
          retryCnt    <= '0;
          ceOut       <= 1'b1;
          opSet       <= (opcode == OP_SET);
          state       <= (opcode == OP_CHECK) ? S_CHK_RD : S_CTL_WR;
        end
        S_CTL_WR: if (ackSeen) state <= S_CTL_RD;
        S_CTL_RD: if (ackSeen) begin
          if (busyBit) begin
            ceOut  <= 1'b0;
            gapCnt <= '0;
            if (retryLast) begin
              timeoutErr <= 1'b1;
              state      <= S_END_GAP;
            end else begin
              retryCnt <= retryCnt + 1'b1;
              state    <= S_RETRY_GAP;
            end
          end else begin
            state <= S_XFER;
          end
        end
        S_RETRY_GAP: begin
          if (gapDone) begin
            ceOut <= 1'b1;
            state <= S_CTL_WR;
          end else gapCnt <= gapCnt + 1'b1;
        end
        S_XFER: if (ackSeen && lastStep) begin
          ceOut  <= 1'b0;
          gapCnt <= '0;
          state  <= S_END_GAP;
        end
        S_END_GAP: begin
          if (gapDone) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else gapCnt <= gapCnt + 1'b1;
        end
        S_CHK_RD: if (ackSeen) begin
          if (stopBit) state <= S_CHK_INT;
          else begin
            ceOut  <= 1'b0;
            gapCnt <= '0;
            state  <= S_END_GAP;
          end
        end
        S_CHK_INT: if (ackSeen) state <= S_CHK_CTL;
        S_CHK_CTL: if (ackSeen) state <= S_CHK_POLL;
        S_CHK_POLL: if (ackSeen) begin
          if (busyBit) begin
            if (retryLast) begin
              timeoutErr <= 1'b1;
              ceOut      <= 1'b0;
              gapCnt     <= '0;
              state      <= S_END_GAP;
            end else retryCnt <= retryCnt + 1'b1;
          end else begin
            invalidTime <= 1'b1;
            opSet       <= 1'b1;
            retryCnt    <= '0;
            state       <= S_CTL_WR;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11: requests only with chip enable high, one cycle wide
  assert_req_ce_R11: assert property (@(posedge clk) disable iff (!rstN)
    regReq |-> ceOut);
  assert_req_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    regReq |=> !regReq);
  // R8: done is a single pulse with chip enable low
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_ce_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !ceOut);
  // R5: retry counter bounded, timeout leaves chip enable low
  assert_retry_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    retryCnt < RETRY_W'(RETRY_LIMIT));
  assert_timeout_ce_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> !ceOut);
  // R4: chip enable only rises from idle or after a retry gap
  assert_ce_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ceOut) |-> ($past(state) == S_IDLE || $past(state) == S_RETRY_GAP));
endmodule

// File: rtl/rtc_time_seq.sv
module rtc_time_seq
  import rtc_seq_pkg::*;
#(
  parameter int CE_GAP      = 175,
  parameter int RETRY_LIMIT = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] opcode,
  input  logic [7:0] secIn,
  input  logic [7:0] minIn,
  input  logic [7:0] hourIn,
  input  logic [7:0] dayIn,
  input  logic [7:0] monIn,
  input  logic [7:0] yearIn,
  input  logic [3:0] wdayIn,
  output logic [7:0] secOut,
  output logic [7:0] minOut,
  output logic [7:0] hourOut,
  output logic [7:0] dayOut,
  output logic [7:0] monOut,
  output logic [7:0] yearOut,
  output logic [3:0] wdayOut,
  output logic       done,
  output logic       invalidTime,
  output logic       timeoutErr,
  output logic       ceOut,
  output logic       regReq,
  output logic       regWrite,
  output logic [3:0] regAddr,
  output logic [3:0] regWrData,
  input  logic       regAck,
  input  logic [3:0] regRdData
);
  dp_strobe_t                        strobe;
  logic [NUM_FIELDS-2:0][BYTE_W-1:0] hostBytes;
  logic [NUM_FIELDS-2:0][BYTE_W-1:0] timeBytes;
  logic [ADDR_W-1:0]                 stepAddr;
  logic [NIB_W-1:0]                  stepWrNib;
  logic                              lastStep;

  assign hostBytes = {yearIn, monIn, dayIn, hourIn, minIn, secIn};
  assign {yearOut, monOut, dayOut, hourOut, minOut, secOut} = timeBytes;

  rtc_seq_ctrl #(.CE_GAP(CE_GAP), .RETRY_LIMIT(RETRY_LIMIT)) uCtrl (
    .clk, .rstN, .start, .opcode, .regAck,
    .busyBit(regRdData[0]), .stopBit(regRdData[1]),
    .stepAddr, .stepWrNib, .lastStep,
    .ceOut, .regReq, .regWrite, .regAddr, .regWrData,
    .done, .invalidTime, .timeoutErr, .strobe
  );

  rtc_seq_data uData (
    .clk, .rstN, .strobe, .hostBytes, .hostWday(wdayIn), .rdNib(regRdData),
    .timeBytes, .timeWday(wdayOut), .stepAddr, .stepWrNib, .lastStep
  );
endmodule

// File: tb/rtc_time_seq_test.sv
module rtc_time_seq_test;
  localparam int GAP = 6;
  localparam int LIM = 4;

  logic clk = 0, rstN = 0, start = 0;
  logic [1:0] opcode = 0;
  logic [7:0] secIn = 0, minIn = 0, hourIn = 0, dayIn = 0, monIn = 0, yearIn = 0;
  logic [3:0] wdayIn = 0;
  logic [7:0] secOut, minOut, hourOut, dayOut, monOut, yearOut;
  logic [3:0] wdayOut;
  logic done, invalidTime, timeoutErr, ceOut, regReq, regWrite, regAck;
  logic [3:0] regAddr, regWrData, regRdData;

  always #2 clk = ~clk;

  rtc_time_seq #(.CE_GAP(GAP), .RETRY_LIMIT(LIM)) uut (.*);

  int total = 0, bad = 0;

  // ---------------- chip model ----------------
  logic [3:0] cfgReg [16];
  int cfgBusy = 0, cfgAdj = 0;
  logic cfgXstp = 0, cfgLoad = 0;

  logic [3:0] mReg [16];
  logic mXstp = 0, pend = 0, seenHigh = 0;
  int busyLeft = 0, adjBusy = 0, lat = 0;
  logic rqW = 0; logic [3:0] rqA = 0, rqD = 0;
  int logN = 0, doneSeen = 0, shortGap = 0, ceViol = 0, lowRun = 0, doneLow = 0;
  logic logW [64]; logic [3:0] logA [64]; logic [3:0] logD [64];
  logic mAck = 0; logic [3:0] mRd = 0;
  assign regAck = mAck;
  assign regRdData = mRd;

  always @(posedge clk) begin
    mAck <= 0;
    if (cfgLoad) begin
      for (int i = 0; i < 16; i++) mReg[i] <= cfgReg[i];
      busyLeft <= cfgBusy; adjBusy <= cfgAdj; mXstp <= cfgXstp;
      logN <= 0; doneSeen <= 0; shortGap <= 0; ceViol <= 0; pend <= 0;
    end else begin
      if (done) begin doneSeen <= doneSeen + 1; doneLow <= lowRun; end
      if (!ceOut) lowRun <= lowRun + 1;
      else begin
        if (seenHigh && lowRun != 0 && lowRun < GAP) shortGap <= shortGap + 1;
        lowRun <= 0; seenHigh <= 1;
      end
      if (regReq) begin
        if (!ceOut) ceViol <= ceViol + 1;
        if (logN < 64) begin logW[logN] <= regWrite; logA[logN] <= regAddr; logD[logN] <= regWrData; end
        logN <= logN + 1;
        pend <= 1; lat <= 1; rqW <= regWrite; rqA <= regAddr; rqD <= regWrData;
      end else if (pend) begin
        if (lat != 0) lat <= lat - 1;
        else begin
          mAck <= 1; pend <= 0;
          if (rqW) begin
            mReg[rqA] <= rqD;
            if (rqA == 4'hE && rqD == 4'h7) begin mXstp <= 0; busyLeft <= adjBusy; end
          end else if (rqA == 4'hE) begin
            mRd <= {1'b0, mReg[14][2], mXstp, busyLeft != 0};
            if (busyLeft != 0) busyLeft <= busyLeft - 1;
          end else mRd <= mReg[rqA];
        end
      end
    end
  end

  // ---------------- expected access list ----------------
  int expN = 0;
  logic expW [64]; logic [3:0] expA [64]; logic [3:0] expD [64];
  int baseOf [6] = '{0, 2, 4, 8, 10, 12};

  task automatic push(input logic w, input int a, input int d);
    expW[expN] = w; expA[expN] = 4'(a); expD[expN] = 4'(d); expN++;
  endtask

  task automatic pushPre(input int nBusy);
    for (int i = 0; i <= nBusy && i < LIM; i++) begin push(1, 14, 4); push(0, 14, 0); end
  endtask

  task automatic pushTime(input logic w, input logic [7:0] b [6], input logic [3:0] wd);
    for (int f = 0; f < 6; f++) begin
      push(w, baseOf[f], b[f][3:0]);
      push(w, baseOf[f] + 1, b[f][7:4]);
    end
    push(w, 6, wd);
  endtask

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic chkLog(input string tag);
    chk(logN == expN, {tag, " access count"}, logN, expN);
    for (int i = 0; i < expN && i < logN; i++) begin
      chk(logW[i] == expW[i] && logA[i] == expA[i] && (!expW[i] || logD[i] == expD[i]),
          {tag, " access entry"}, {logW[i], 3'b0, logA[i], logD[i]}, {expW[i], 3'b0, expA[i], expD[i]});
    end
    chk(ceViol == 0, "R11 request with CE low", ceViol, 0);
    chk(shortGap == 0, "R4 CE low gap short", shortGap, 0);
  endtask

  function automatic logic [7:0] pat(input int p, input int f);
    case (f)
      0: pat = {4'((p + 1) % 6), 4'((3 * p + 2) % 10)};
      1: pat = {4'((2 * p) % 6), 4'((7 * p + 1) % 10)};
      2: pat = {4'(p % 3), 4'((5 * p) % 10)};
      3: pat = {4'((p + 1) % 4), 4'((9 * p + 3) % 10)};
      4: pat = {4'(p % 2), 4'((4 * p) % 10)};
      default: pat = {4'((3 * p) % 10), 4'((7 * p + 5) % 10)};
    endcase
  endfunction

  task automatic configure(input int nb, input int adj, input logic xs);
    @(negedge clk);
    cfgBusy = nb; cfgAdj = adj; cfgXstp = xs; cfgLoad = 1;
    @(negedge clk);
    cfgLoad = 0;
    expN = 0;
  endtask

  task automatic waitDone(input string tag);
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(n < 5000, {tag, " done never seen"}, n, 0);
    @(negedge clk);
    chk(doneLow >= GAP, "R8 CE low before done", doneLow, GAP);
    chk(doneSeen == 1, "R8 one done pulse", doneSeen, 1);
  endtask

  task automatic runOp(input logic [1:0] op);
    @(negedge clk); start = 1; opcode = op;
    @(negedge clk); start = 0; opcode = 0;
  endtask

  logic [7:0] bytesE [6];
  logic [7:0] outs [6];

  task automatic grabOuts();
    outs[0] = secOut; outs[1] = minOut; outs[2] = hourOut;
    outs[3] = dayOut; outs[4] = monOut; outs[5] = yearOut;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) cfgReg[i] = 0;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!ceOut && !regReq && !done && !invalidTime && !timeoutErr, "R1 during reset",
        {ceOut, regReq, done, invalidTime, timeoutErr}, 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    chk(!ceOut && !regReq && !done && !invalidTime && !timeoutErr, "R1 after reset",
        {ceOut, regReq, done, invalidTime, timeoutErr}, 0);

    // R6 / R3 / R4 read sweep with busy counts 0..LIM-1
    for (int p = 0; p < 8; p++) begin
      for (int f = 0; f < 6; f++) begin
        bytesE[f] = pat(p, f);
        cfgReg[baseOf[f]] = bytesE[f][3:0];
        cfgReg[baseOf[f] + 1] = bytesE[f][7:4];
      end
      cfgReg[6] = 4'(p % 7);
      configure(p % LIM, 0, 0);
      pushPre(p % LIM);
      pushTime(0, bytesE, 4'(p % 7));
      runOp(2'b01);
      waitDone("R6 read");
      chkLog("R3 R4 R6 read");
      grabOuts();
      for (int f = 0; f < 6; f++) chk(outs[f] == bytesE[f], "R6 packed byte", outs[f], bytesE[f]);
      chk(wdayOut == 4'(p % 7), "R6 weekday", wdayOut, p % 7);
      chk(!timeoutErr, "R5 no timeout", timeoutErr, 0);
    end

    // R5 timeout in busy preamble
    configure(LIM, 0, 0);
    pushPre(LIM);
    runOp(2'b01);
    waitDone("R5 timeout");
    chkLog("R5 timeout");
    chk(timeoutErr, "R5 timeoutErr set", timeoutErr, 1);

    // R7 set sweep
    for (int p = 0; p < 6; p++) begin
      for (int f = 0; f < 6; f++) bytesE[f] = pat(p + 10, f);
      configure((p + 1) % LIM, 0, 0);
      @(negedge clk);
      secIn = bytesE[0]; minIn = bytesE[1]; hourIn = bytesE[2];
      dayIn = bytesE[3]; monIn = bytesE[4]; yearIn = bytesE[5]; wdayIn = 4'((p + 3) % 7);
      pushPre((p + 1) % LIM);
      pushTime(1, bytesE, 4'((p + 3) % 7));
      runOp(2'b10);
      waitDone("R7 set");
      chkLog("R7 set");
      chk(!timeoutErr, "R2 timeoutErr cleared by start", timeoutErr, 0);
      chk(mReg[1] == bytesE[0][7:4] && mReg[12] == bytesE[5][3:0], "R7 chip contents",
          {mReg[1], mReg[12]}, {bytesE[0][7:4], bytesE[5][3:0]});
      grabOuts();
      for (int f = 0; f < 6; f++) chk(outs[f] == bytesE[f], "R7 outputs follow written", outs[f], bytesE[f]);
    end

    // R2 opcode 00 ignored
    configure(0, 0, 0);
    runOp(2'b00);
    repeat (30) @(negedge clk);
    chk(logN == 0 && doneSeen == 0 && !ceOut, "R2 opcode 00 ignored", logN, 0);

    // R2 start ignored while running
    configure(1, 0, 0);
    for (int f = 0; f < 6; f++) bytesE[f] = pat(3, f);
    secIn = bytesE[0]; minIn = bytesE[1]; hourIn = bytesE[2];
    dayIn = bytesE[3]; monIn = bytesE[4]; yearIn = bytesE[5]; wdayIn = 4'd2;
    pushPre(1);
    pushTime(1, bytesE, 4'd2);
    runOp(2'b10);
    repeat (5) @(negedge clk);
    runOp(2'b01);
    waitDone("R2 busy start");
    repeat (40) @(negedge clk);
    chkLog("R2 busy start ignored");
    chk(doneSeen == 1, "R2 no second job", doneSeen, 1);

    // R9 check, oscillator running
    cfgReg[14] = 4'h4;
    configure(0, 0, 0);
    push(0, 14, 0);
    runOp(2'b11);
    waitDone("R9 check");
    chkLog("R9 check clean");
    chk(!invalidTime, "R9 invalidTime clear", invalidTime, 0);

    // R10 check with oscillator stop, adjust busy 0 and 2
    for (int k = 0; k <= 2; k += 2) begin
      configure(0, k, 1);
      for (int f = 0; f < 6; f++) bytesE[f] = (f == 3 || f == 4) ? 8'h01 : 8'h00;
      push(0, 14, 0); push(1, 7, 0); push(1, 14, 7);
      for (int i = 0; i <= k; i++) push(0, 14, 0);
      pushPre(0);
      pushTime(1, bytesE, 4'd0);
      runOp(2'b11);
      waitDone("R10 check");
      chkLog("R10 check recover");
      chk(invalidTime, "R10 invalidTime set", invalidTime, 1);
      grabOuts();
      for (int f = 0; f < 6; f++) chk(outs[f] == bytesE[f], "R10 default time", outs[f], bytesE[f]);
      chk(mReg[8] == 4'h1 && mReg[10] == 4'h1 && mReg[7] == 4'h0, "R10 chip default",
          {mReg[8], mReg[10], mReg[7]}, 12'h110);
    end

    // R2 invalidTime cleared by next accepted start
    configure(0, 0, 0);
    runOp(2'b01);
    waitDone("R2 clear");
    chk(!invalidTime, "R2 invalidTime cleared", invalidTime, 0);

    // R5 / R10 poll timeout
    configure(0, LIM, 1);
    push(0, 14, 0); push(1, 7, 0); push(1, 14, 7);
    for (int i = 0; i < LIM; i++) push(0, 14, 0);
    runOp(2'b11);
    waitDone("R5 poll timeout");
    chkLog("R5 poll timeout");
    chk(timeoutErr && !invalidTime, "R5 poll timeout flags", {timeoutErr, invalidTime}, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule